// File: doc/BRIEF.md
# Interrupt Status and Control Register Block

This block is the register front end of a bus peripheral. It keeps a control word, a combined interrupt register and a read-only status word. Every register can be reached at three addresses: its base address for a plain write, base+4 to OR bits in, and base+8 to clear the bits written as 1. The two atomic forms let software change single bits without a read-modify-write sequence.

The interrupt register holds eight event flags in its low byte and their enables in the byte above. A one-cycle pulse from the transfer engine sets a flag. The flag stays set until software clears it. The block drives one registered interrupt line that is high while any flag is set together with its enable.

The status word carries a sticky flag for a missing acknowledge, which is cleared through the interrupt register's set alias. It also reflects two busy inputs. One bit of the control word holds the block in soft reset. While that bit is set, all flags and enables are forced to zero.

Top module: `csr_irq_block`

## Requirements
- R1: After reset every register reads as zero, `irq` is low and `soft_rst` is low.
- R2: A write to the base address of the control word (0x00) or the interrupt register (0x40) loads the written value. The interrupt register keeps only bits 15:0; its other bits read as zero.
- R3: For the control word and the interrupt register, a write to base+4 ORs the data into the register and a write to base+8 clears each bit written as 1. All other bits are left unchanged.
- R4: A pulse on `evt_pulse[i]` sets flag bit i of the interrupt register, and the flag holds until software clears it. The bit order is: 0 slave event, 1 slave stop, 2 arbitration loss, 3 early end, 4 oversize transfer, 5 no acknowledge, 6 engine done, 7 bus idle.
- R5: When an event pulse and a software write that clears the same flag fall in the same cycle, the flag ends up set.
- R6: `irq` rises one cycle after a flag and its enable are both set. It falls one cycle after no enabled flag remains. A flag whose enable is clear does not raise `irq`.
- R7: The enable for flag i is bit i+8 of the interrupt register.
- R8: A pulse on `nak_pulse` sets the sticky flag at bit 28 of the status word (0x50). Writing 1 to bit 28 through the interrupt register's set alias (0x44) clears it. If a pulse arrives in the same cycle as that write, the flag stays set. Bit 28 of the interrupt register itself always reads 0.
- R9: Status word bit 11 reads `bus_busy`, bit 10 reads `clkgen_busy`, and every other bit except 28 reads 0. Writes to the status word change nothing.
- R10: Bit 31 of the control word is the soft-reset bit and drives `soft_rst`. Starting on the cycle after it is set, and for as long as it stays set, all flags, enables and the sticky flag are held at zero and event pulses are ignored. The control word itself keeps its value.
- R11: Reads from any address outside the three registers and their aliases return zero, and writes to those addresses change nothing. An address with bits 1:0 not zero, or an offset of +0xC, counts as outside.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe; `rdata` is valid in the same cycle |
| addr | input | 8 | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data; zero when no read is in progress |
| evt_pulse | input | 8 | Event pulses from the engine, one per flag |
| nak_pulse | input | 1 | Pulse that sets the missing-acknowledge flag |
| bus_busy | input | 1 | Bus-busy indication shown in the status word |
| clkgen_busy | input | 1 | Clock-generator-busy indication shown in the status word |
| irq | output | 1 | Registered interrupt request |
| soft_rst | output | 1 | Soft-reset bit of the control word |

## Verification
Bit changes are driven through all three alias forms, using data that mixes bits already set with bits still clear. The results show that a set leaves existing ones in place, a clear touches only the ones written, and a base write replaces the whole field.

Event pulses are applied with and without a matching enable, which separates a raised flag from a raised interrupt line. The line is sampled in the cycle right after the flag changes and again one cycle later, which pins down its one-cycle register delay.

Event pulses and the missing-acknowledge pulse are also made to coincide with software clears, which confirms the event wins. Pulses sent while soft reset is held are shown to leave no trace once the reset bit is released.

// File: rtl/csr_irq_block.sv
module csr_irq_block #(
  parameter int AW        = 8,
  parameter int DW        = 32,
  parameter int NEV       = 8,
  parameter int NAK_BIT   = 28,
  parameter int SRST_BIT  = 31,
  parameter int BUSY_BIT  = 11,
  parameter int CLKB_BIT  = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic [NEV-1:0] evt_pulse,
  input  logic          nak_pulse,
  input  logic          bus_busy,
  input  logic          clkgen_busy,
  output logic          irq,
  output logic          soft_rst
);

  localparam int EN_LSB = 8;
  localparam logic [AW-1:0] OFS_CTRL = AW'('h00);
  localparam logic [AW-1:0] OFS_INT  = AW'('h40);
  localparam logic [AW-1:0] OFS_STAT = AW'('h50);
  localparam logic [1:0] AL_NORM = 2'd0;
  localparam logic [1:0] AL_SET  = 2'd1;
  localparam logic [1:0] AL_CLR  = 2'd2;

  logic [DW-1:0]  ctrl_q;
  logic [NEV-1:0] flag_q;
  logic [NEV-1:0] en_q;
  logic           nak_q;
  logic           irq_q;

  logic [AW-1:0] base;
  logic [1:0]    alias_sel;
  logic          aligned;
  logic          hit_ctrl, hit_int, hit_stat;
  logic          wr_ctrl, wr_int, nak_clr;
  logic [DW-1:0]  ctrl_n;
  logic [NEV-1:0] flag_n;
  logic [NEV-1:0] en_n;
  logic           srst;

  assign base      = {addr[AW-1:4], 4'h0};
  assign alias_sel = addr[3:2];
  assign aligned   = (addr[1:0] == 2'b00) && (alias_sel != 2'b11);
  assign hit_ctrl  = aligned && (base == OFS_CTRL);
  assign hit_int   = aligned && (base == OFS_INT);
  assign hit_stat  = aligned && (base == OFS_STAT);
  assign wr_ctrl   = wr_en && hit_ctrl;
  assign wr_int    = wr_en && hit_int;
  assign nak_clr   = wr_int && (alias_sel == AL_SET) && wdata[NAK_BIT];
  assign srst      = ctrl_q[SRST_BIT];
  assign soft_rst  = srst;
  assign irq       = irq_q;

  always_comb begin
    case (alias_sel)
      AL_SET: begin
        ctrl_n = ctrl_q | wdata;
        flag_n = flag_q | wdata[NEV-1:0];
        en_n   = en_q | wdata[EN_LSB +: NEV];
      end
      AL_CLR: begin
        ctrl_n = ctrl_q & ~wdata;
        flag_n = flag_q & ~wdata[NEV-1:0];
        en_n   = en_q & ~wdata[EN_LSB +: NEV];
      end
      default: begin
        ctrl_n = wdata;
        flag_n = wdata[NEV-1:0];
        en_n   = wdata[EN_LSB +: NEV];
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      flag_q <= '0;
      en_q   <= '0;
      nak_q  <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= ctrl_n;
      if (srst) begin
        flag_q <= '0;
        en_q   <= '0;
        nak_q  <= 1'b0;
      end else begin
        flag_q <= (wr_int ? flag_n : flag_q) | evt_pulse;
        if (wr_int) en_q <= en_n;
        nak_q  <= nak_pulse | (nak_q & ~nak_clr);
      end
      irq_q <= |(flag_q & en_q);
    end
  end

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      if (hit_ctrl) rdata = ctrl_q;
      else if (hit_int) begin
        rdata[NEV-1:0]       = flag_q;
        rdata[EN_LSB +: NEV] = en_q;
      end else if (hit_stat) begin
        rdata[NAK_BIT]  = nak_q;
        rdata[BUSY_BIT] = bus_busy;
        rdata[CLKB_BIT] = clkgen_busy;
      end
    end
  end

  p_evt_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!srst && (evt_pulse != '0)) |=> ((flag_q & $past(evt_pulse)) == $past(evt_pulse)));

  p_evt_beats_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!srst && wr_int && (alias_sel == AL_CLR) && ((evt_pulse & wdata[NEV-1:0]) != '0))
    |=> ((flag_q & $past(evt_pulse)) == $past(evt_pulse)));

  p_irq_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((flag_q & en_q) == '0) |=> !irq);

  p_nak_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (nak_q && !nak_clr && !srst) |=> nak_q);

  p_srst_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> ((flag_q == '0) && (en_q == '0) && !nak_q));

endmodule

// File: tb/csr_irq_block_tb_top.sv
`timescale 1ns/1ps
module csr_irq_block_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [7:0]  evt_pulse = '0;
  logic        nak_pulse = 1'b0;
  logic        bus_busy = 1'b0;
  logic        clkgen_busy = 1'b0;
  logic        irq;
  logic        soft_rst;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  csr_irq_block dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .evt_pulse(evt_pulse), .nak_pulse(nak_pulse),
    .bus_busy(bus_busy), .clkgen_busy(clkgen_busy), .irq(irq), .soft_rst(soft_rst)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    rd_en = 1'b1; addr = a;
    #0.5;
    d = rdata;
    rd_en = 1'b0;
  endtask

  task automatic pulse(input logic [7:0] e, input logic n);
    @(negedge clk);
    evt_pulse = e; nak_pulse = n;
    @(negedge clk);
    evt_pulse = '0; nak_pulse = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(8'h00, v); chk("R1 ctrl", v, 32'h0);
    rd(8'h40, v); chk("R1 int", v, 32'h0);
    rd(8'h50, v); chk("R1 stat", v, 32'h0);
    chk("R1 irq", {31'd0, irq}, 32'd0);
    chk("R1 soft_rst", {31'd0, soft_rst}, 32'd0);
  endtask

  task automatic t_aliases();
    logic [31:0] v;
    wr(8'h00, 32'h0000_1234); rd(8'h00, v); chk("R2 ctrl base", v, 32'h0000_1234);
    wr(8'h04, 32'h00F0_0004); rd(8'h00, v); chk("R3 ctrl set", v, 32'h00F0_1234);
    wr(8'h08, 32'h0000_0034); rd(8'h00, v); chk("R3 ctrl clr", v, 32'h00F0_1200);
    wr(8'h00, 32'h0);
    wr(8'h40, 32'hFFFF_A5C3); rd(8'h40, v); chk("R2 int base", v, 32'h0000_A5C3);
    wr(8'h44, 32'h0000_0A0C); rd(8'h40, v); chk("R3 int set", v, 32'h0000_AFCF);
    wr(8'h48, 32'h0000_8081); rd(8'h40, v); chk("R3 int clr", v, 32'h0000_2F4E);
    wr(8'h40, 32'h0);
  endtask

  task automatic t_events();
    logic [31:0] v;
    pulse(8'h21, 1'b0); rd(8'h40, v); chk("R4 flags set", v, 32'h0000_0021);
    repeat (3) @(negedge clk);
    rd(8'h40, v); chk("R4 flags hold", v, 32'h0000_0021);
    pulse(8'h80, 1'b0); rd(8'h40, v); chk("R4 flag 7", v, 32'h0000_00A1);
    chk("R6 no irq without enable", {31'd0, irq}, 32'd0);
    @(negedge clk);
    chk("R6 no irq without enable later", {31'd0, irq}, 32'd0);
    @(negedge clk);
    evt_pulse = 8'h01; wr_en = 1'b1; addr = 8'h48; wdata = 32'h0000_0003;
    @(negedge clk);
    evt_pulse = '0; wr_en = 1'b0; wdata = '0;
    rd(8'h40, v); chk("R5 event beats clear", v, 32'h0000_00A1);
    wr(8'h40, 32'h0);
  endtask

  task automatic t_irq();
    logic [31:0] v;
    wr(8'h40, 32'h0000_0800); // R7: enable flag 3 at bit 11
    pulse(8'h04, 1'b0);
    @(negedge clk);
    chk("R7 other enable no irq", {31'd0, irq}, 32'd0);
    pulse(8'h08, 1'b0);
    chk("R6 irq latency first cycle", {31'd0, irq}, 32'd0);
    @(negedge clk);
    chk("R6 irq high", {31'd0, irq}, 32'd1);
    wr(8'h48, 32'h0000_0008);
    chk("R6 irq still high one cycle", {31'd0, irq}, 32'd1);
    @(negedge clk);
    chk("R6 irq low after clear", {31'd0, irq}, 32'd0);
    rd(8'h40, v); chk("R7 enable kept", v, 32'h0000_0804);
    wr(8'h40, 32'h0);
  endtask

  task automatic t_status();
    logic [31:0] v;
    bus_busy = 1'b1; clkgen_busy = 1'b0;
    rd(8'h50, v); chk("R9 bus busy", v, 32'h0000_0800);
    bus_busy = 1'b0; clkgen_busy = 1'b1;
    rd(8'h50, v); chk("R9 clkgen busy", v, 32'h0000_0400);
    clkgen_busy = 1'b0;
    wr(8'h50, 32'hFFFF_FFFF); wr(8'h54, 32'hFFFF_FFFF);
    rd(8'h50, v); chk("R9 status write ignored", v, 32'h0);
    pulse(8'h00, 1'b1);
    rd(8'h50, v); chk("R8 nak set", v, 32'h1000_0000);
    rd(8'h40, v); chk("R8 int bit28 reads 0", v, 32'h0);
    wr(8'h40, 32'h1000_0000);
    rd(8'h50, v); chk("R8 base write no clear", v, 32'h1000_0000);
    @(negedge clk);
    nak_pulse = 1'b1; wr_en = 1'b1; addr = 8'h44; wdata = 32'h1000_0000;
    @(negedge clk);
    nak_pulse = 1'b0; wr_en = 1'b0; wdata = '0;
    rd(8'h50, v); chk("R8 pulse beats clear", v, 32'h1000_0000);
    wr(8'h44, 32'h1000_0000);
    rd(8'h50, v); chk("R8 nak cleared", v, 32'h0);
    rd(8'h40, v); chk("R8 int unchanged", v, 32'h0);
  endtask

  task automatic t_soft_reset();
    logic [31:0] v;
    wr(8'h40, 32'h0000_FF00);
    pulse(8'h11, 1'b1);
    @(negedge clk);
    chk("R6 irq before srst", {31'd0, irq}, 32'd1);
    wr(8'h04, 32'h8000_0000);
    chk("R10 soft_rst out", {31'd0, soft_rst}, 32'd1);
    @(negedge clk);
    rd(8'h40, v); chk("R10 int cleared", v, 32'h0);
    rd(8'h50, v); chk("R10 nak cleared", v, 32'h0);
    pulse(8'hFF, 1'b1);
    wr(8'h44, 32'h0000_FFFF);
    rd(8'h40, v); chk("R10 held zero", v, 32'h0);
    rd(8'h00, v); chk("R10 ctrl kept", v, 32'h8000_0000);
    @(negedge clk);
    chk("R10 irq low", {31'd0, irq}, 32'd0);
    wr(8'h08, 32'h8000_0000);
    chk("R10 soft_rst released", {31'd0, soft_rst}, 32'd0);
    rd(8'h40, v); chk("R10 no trace after release", v, 32'h0);
    rd(8'h50, v); chk("R10 nak no trace", v, 32'h0);
    pulse(8'h02, 1'b0);
    rd(8'h40, v); chk("R10 events resume", v, 32'h0000_0002);
    wr(8'h40, 32'h0);
  endtask

  task automatic t_unmapped();
    logic [31:0] v;
    wr(8'h00, 32'h0000_00AA);
    wr(8'h40, 32'h0000_0101);
    wr(8'h20, 32'hFFFF_FFFF);
    wr(8'h0C, 32'hFFFF_FFFF);
    wr(8'h4C, 32'hFFFF_FFFF);
    wr(8'h41, 32'h0000_0000);
    rd(8'h20, v); chk("R11 unmapped read", v, 32'h0);
    rd(8'h4C, v); chk("R11 plus C read", v, 32'h0);
    rd(8'h02, v); chk("R11 misaligned read", v, 32'h0);
    rd(8'h00, v); chk("R11 ctrl untouched", v, 32'h0000_00AA);
    rd(8'h40, v); chk("R11 int untouched", v, 32'h0000_0101);
    rd(8'h48, v); chk("R3 read via clr alias", v, 32'h0000_0101);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_aliases();
    t_events();
    t_irq();
    t_status();
    t_soft_reset();
    t_unmapped();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule